// File: doc/BRIEF.md
# Time-over-threshold hit time-stamp encoder

This block is the digital half of a shared time-to-digital converter bank that serves a group of pixels at the end of a column. A discriminator pulse whose width tracks the deposited charge arrives on one line. At its leading edge and again at its trailing edge, the block freezes a snapshot of the delay-line taps and the current value of a free-running coarse counter. Each edge has its own holding register. The analog delay line is modelled as a tap vector input.

Each tap snapshot is read as a thermometer code. A three-way majority vote on neighbouring taps removes isolated bubbles. The snapshot is then reduced to a 5-bit fine code. Once both edges are held, the block issues one hit record with the pixel address, both coarse values and either the two fine codes (compact form) or the two full snapshots (raw form). Alongside the record it gives the pulse width in fine-bin units, which downstream logic uses for time-walk correction. While a leading edge waits for its record, the bank is busy. A new leading edge that arrives then is dropped and counted.

Top module: `tot_stamp_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `rec_valid`, `busy`, `lost_cnt`, `rec_data` and `pulse_width` to zero at that edge.
- R2: A rising edge of `tot_in` (sampled 1 after a sampled 0) seen while not busy is captured, and `busy` is 1 from the next cycle until the cycle in which the record is presented. In that cycle `busy` is 0.
- R3: After a captured rising edge, the first sampled 0 on `tot_in` captures the falling edge. `rec_valid` is then high for exactly one cycle, starting at the second clock edge after the edge at which `tot_in` was first sampled low.
- R4: Fine code of a snapshot: voted tap i is the majority of taps i-1, i, i+1, with tap -1 taken as 1 and tap 32 taken as 0. The code is the lowest i whose voted tap is 0, or 31 if no voted tap is 0.
- R5: The coarse counter is cleared by reset and adds 1 (mod 64) on every clock edge after that. Each edge stores the counter value that is present at the clock edge where that edge is detected, together with the taps sampled at the same clock edge.
- R6: With `raw_mode`=0, `rec_data` holds zeros in bits 80..27, the address in 26..22, the rising coarse in 21..16, the rising fine in 15..11, the falling coarse in 10..5 and the falling fine in 4..0.
- R7: With `raw_mode`=1 (sampled in the cycle the record is issued), `rec_data` holds the address in 80..76, the rising coarse in 75..70, the rising snapshot in 69..38, the falling coarse in 37..32 and the falling snapshot in 31..0.
- R8: `pulse_width`, updated together with the record, equals (falling coarse*32 + falling fine) - (rising coarse*32 + rising fine) mod 2048.
- R9: A rising edge detected while `busy` is 1 is not captured and adds 1 to `lost_cnt`, which wraps at 2^LOST_W. The falling edge that ends that pulse is ignored: no record follows, and `busy` stays 0.
- R10: The address in the record is the value of `pix_addr` at the clock edge that captured the rising edge. Changes to `pix_addr` or `taps` after the capture do not affect the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tot_in | input | 1 | Discriminator pulse from the pixel group |
| taps | input | TAPS (32) | Delay-line tap snapshot |
| pix_addr | input | ADDR_W (5) | Address of the firing pixel |
| raw_mode | input | 1 | 1 selects the unencoded record |
| rec_valid | output | 1 | One-cycle strobe for a new record |
| rec_data | output | 2*(CRS_W+TAPS)+ADDR_W (81) | Hit record |
| pulse_width | output | CRS_W+FINE_W (11) | Pulse width in fine bins |
| busy | output | 1 | Bank holds an unfinished hit |
| lost_cnt | output | LOST_W (8) | Count of dropped leading edges |

## Verification
The bench keeps TAPS=32, CRS_W=6 and ADDR_W=5 and lowers LOST_W to 3, so the lost-hit counter wraps after eight drops within a short run. With a 6-bit coarse counter, hundreds of random pulses cross the counter wrap many times. This produces falling coarse values below the rising ones and exercises the modulo width. Random thermometer positions from 0 to 32, with injected single bubbles and a few directed snapshots (all ones, all zeros, an inner hole, a stray high tap), cover the vote at both ends of the line.

// File: rtl/tse_pkg.sv
package tse_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EMIT = 2'd2
  } bank_state_t;
endpackage

// File: rtl/tse_seq.sv
module tse_seq #(
  parameter int LOST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tot_in,
  output logic              cap_rise,
  output logic              cap_fall,
  output logic              emit,
  output logic              busy,
  output logic [LOST_W-1:0] lost_cnt
);
  import tse_pkg::*;

  bank_state_t state;
  logic        tot_q;
  logic        rise_evt;
  logic        fall_evt;

  // previous line level, no reset needed: state is held idle in reset
  always_ff @(posedge clk) tot_q <= tot_in;

  assign rise_evt = tot_in & ~tot_q;
  assign fall_evt = ~tot_in & tot_q;

  assign cap_rise = (state == ST_IDLE) && rise_evt;
  assign cap_fall = (state == ST_WAIT) && fall_evt;
  assign emit     = (state == ST_EMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      lost_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (rise_evt) begin
          state <= ST_WAIT;
          busy  <= 1'b1;
        end
        ST_WAIT: if (fall_evt) state <= ST_EMIT;
        default: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          if (rise_evt) lost_cnt <= lost_cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/tse_hit_reg.sv
module tse_hit_reg #(
  parameter int TAPS  = 32,
  parameter int CRS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [TAPS-1:0]  taps_in,
  input  logic [CRS_W-1:0] crs_in,
  output logic [TAPS-1:0]  taps_q,
  output logic [CRS_W-1:0] crs_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      taps_q <= '0;
      crs_q  <= '0;
    end else if (cap) begin
      taps_q <= taps_in;
      crs_q  <= crs_in;
    end
  end
endmodule

// File: rtl/tse_therm_enc.sv
module tse_therm_enc #(
  parameter int TAPS   = 32,
  localparam int FINE_W = $clog2(TAPS)
) (
  input  logic [TAPS-1:0]   therm,
  output logic [FINE_W-1:0] code
);
  logic [TAPS-1:0] voted;

  for (genvar i = 0; i < TAPS; i++) begin : g_vote
    logic lo, hi;
    if (i == 0) begin : g_lo_edge
      assign lo = 1'b1;
    end else begin : g_lo_mid
      assign lo = therm[i-1];
    end
    if (i == TAPS-1) begin : g_hi_edge
      assign hi = 1'b0;
    end else begin : g_hi_mid
      assign hi = therm[i+1];
    end
    assign voted[i] = (lo & therm[i]) | (therm[i] & hi) | (lo & hi);
  end

  // lowest voted zero marks the 1-to-0 boundary; saturate when none
  always_comb begin
    code = FINE_W'(TAPS-1);
    for (int i = TAPS-1; i >= 0; i--) begin
      if (!voted[i]) code = FINE_W'(i);
    end
  end
endmodule

// File: rtl/tot_stamp_encoder.sv
module tot_stamp_encoder #(
  parameter int TAPS   = 32,
  parameter int CRS_W  = 6,
  parameter int ADDR_W = 5,
  parameter int LOST_W = 8,
  localparam int FINE_W = $clog2(TAPS),
  localparam int W_W    = CRS_W + FINE_W,
  localparam int ENC_W  = ADDR_W + 2*(CRS_W + FINE_W),
  localparam int RAW_W  = ADDR_W + 2*(CRS_W + TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tot_in,
  input  logic [TAPS-1:0]   taps,
  input  logic [ADDR_W-1:0] pix_addr,
  input  logic              raw_mode,
  output logic              rec_valid,
  output logic [RAW_W-1:0]  rec_data,
  output logic [W_W-1:0]    pulse_width,
  output logic              busy,
  output logic [LOST_W-1:0] lost_cnt
);
  logic              cap_rise, cap_fall, emit;
  logic [CRS_W-1:0]  coarse;
  logic [ADDR_W-1:0] addr_q;
  logic [TAPS-1:0]   snap   [2];
  logic [CRS_W-1:0]  crs_h  [2];
  logic [FINE_W-1:0] fine_h [2];
  logic [ENC_W-1:0]  enc_rec;
  logic [RAW_W-1:0]  raw_rec;
  logic [W_W-1:0]    t_rise, t_fall;

  tse_seq #(.LOST_W(LOST_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tot_in   (tot_in),
    .cap_rise (cap_rise),
    .cap_fall (cap_fall),
    .emit     (emit),
    .busy     (busy),
    .lost_cnt (lost_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) coarse <= '0;
    else     coarse <= coarse + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           addr_q <= '0;
    else if (cap_rise) addr_q <= pix_addr;
  end

  // index 0 holds the leading edge, index 1 the trailing edge
  for (genvar e = 0; e < 2; e++) begin : g_edge
    tse_hit_reg #(.TAPS(TAPS), .CRS_W(CRS_W)) u_hit (
      .clk     (clk),
      .rst     (rst),
      .cap     ((e == 0) ? cap_rise : cap_fall),
      .taps_in (taps),
      .crs_in  (coarse),
      .taps_q  (snap[e]),
      .crs_q   (crs_h[e])
    );
    tse_therm_enc #(.TAPS(TAPS)) u_enc (
      .therm (snap[e]),
      .code  (fine_h[e])
    );
  end

  assign enc_rec = {addr_q, crs_h[0], fine_h[0], crs_h[1], fine_h[1]};
  assign raw_rec = {addr_q, crs_h[0], snap[0], crs_h[1], snap[1]};
  assign t_rise  = {crs_h[0], fine_h[0]};
  assign t_fall  = {crs_h[1], fine_h[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid   <= 1'b0;
      rec_data    <= '0;
      pulse_width <= '0;
    end else begin
      rec_valid <= emit;
      if (emit) begin
        rec_data    <= raw_mode ? raw_rec : RAW_W'(enc_rec);
        pulse_width <= t_fall - t_rise;
      end
    end
  end
endmodule

// File: rtl/tse_checks.sv
module tse_checks #(
  parameter int RAW_W  = 81,
  parameter int W_W    = 11,
  parameter int LOST_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tot_in,
  input logic              rec_valid,
  input logic [RAW_W-1:0]  rec_data,
  input logic [W_W-1:0]    pulse_width,
  input logic              busy,
  input logic [LOST_W-1:0] lost_cnt
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!rec_valid && !busy && lost_cnt == '0 && rec_data == '0 && pulse_width == '0));

  p_busy_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(tot_in) && !busy) |=> busy);

  p_idle_at_record_r2: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> !busy);

  p_record_after_fall_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(tot_in) && busy) |=> ##1 rec_valid);

  p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    rec_valid |=> !rec_valid);

  p_lost_count_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(tot_in) && busy) |=> (lost_cnt == LOST_W'($past(lost_cnt) + 1'b1)));

  p_lost_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !$rose(tot_in) |=> $stable(lost_cnt));
endmodule

bind tot_stamp_encoder tse_checks #(
  .RAW_W  (RAW_W),
  .W_W    (W_W),
  .LOST_W (LOST_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tot_in      (tot_in),
  .rec_valid   (rec_valid),
  .rec_data    (rec_data),
  .pulse_width (pulse_width),
  .busy        (busy),
  .lost_cnt    (lost_cnt)
);

// File: tb/sim_tot_stamp_encoder.sv
module sim_tot_stamp_encoder;
  localparam int LW = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tot_in = 1'b0;
  logic [31:0] taps = '0;
  logic [4:0]  pix_addr = '0;
  logic        raw_mode = 1'b0;
  logic        rec_valid;
  logic [80:0] rec_data;
  logic [10:0] pulse_width;
  logic        busy;
  logic [LW-1:0] lost_cnt;

  int checks = 0;
  int failures = 0;
  int bcnt = 0;
  int exp_lost = 0;

  always #4 clk = ~clk;

  always @(posedge clk) bcnt <= rst ? 0 : (bcnt + 1) % 64;

  tot_stamp_encoder #(.LOST_W(LW)) u0 (
    .clk(clk), .rst(rst), .tot_in(tot_in), .taps(taps), .pix_addr(pix_addr),
    .raw_mode(raw_mode), .rec_valid(rec_valid), .rec_data(rec_data),
    .pulse_width(pulse_width), .busy(busy), .lost_cnt(lost_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [80:0] act, input logic [80:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int fine_of(input logic [31:0] t);
    logic [31:0] v;
    for (int i = 0; i < 32; i++) begin
      logic lo, hi;
      lo = (i == 0) ? 1'b1 : t[i-1];
      hi = (i == 31) ? 1'b0 : t[i+1];
      v[i] = (lo && t[i]) || (t[i] && hi) || (lo && hi);
    end
    for (int i = 0; i < 32; i++) if (!v[i]) return i;
    return 31;
  endfunction

  function automatic logic [31:0] therm(input int p);
    if (p <= 0) return 32'h0;
    if (p >= 32) return 32'hFFFF_FFFF;
    return 32'hFFFF_FFFF >> (32 - p);
  endfunction

  task automatic do_hit(input logic [31:0] rt, input logic [31:0] ft, input logic [4:0] a,
                        input int hi_cyc, input logic rawm, input bit add_lost);
    int rc, fc, rf, ff;
    logic [80:0] exp_d;
    logic [10:0] exp_w;
    @(negedge clk);
    chk(busy == 1'b0, "R2", "idle before hit", 81'(busy), 81'(0));
    tot_in = 1'b1; taps = rt; pix_addr = a; raw_mode = rawm; rc = bcnt;
    for (int k = 1; k < hi_cyc; k++) begin
      @(negedge clk);
      taps = $urandom; pix_addr = 5'($urandom);
      chk(busy == 1'b1, "R2", "busy while high", 81'(busy), 81'(1));
    end
    @(negedge clk);
    chk(busy == 1'b1, "R2", "busy before fall", 81'(busy), 81'(1));
    tot_in = 1'b0; taps = ft; fc = bcnt;
    @(negedge clk);
    chk(rec_valid == 1'b0, "R3", "no strobe at fall capture", 81'(rec_valid), 81'(0));
    taps = $urandom; pix_addr = 5'($urandom);
    if (add_lost) tot_in = 1'b1;
    @(negedge clk);
    rf = fine_of(rt); ff = fine_of(ft);
    if (rawm) exp_d = {a, 6'(rc), rt, 6'(fc), ft};
    else      exp_d = 81'({a, 6'(rc), 5'(rf), 6'(fc), 5'(ff)});
    exp_w = 11'((fc*32 + ff) - (rc*32 + rf));
    chk(rec_valid == 1'b1, "R3", "strobe timing", 81'(rec_valid), 81'(1));
    chk(busy == 1'b0, "R2", "idle with record", 81'(busy), 81'(0));
    chk(rec_data == exp_d, rawm ? "R7" : "R6", "record R4 R5 R10", rec_data, exp_d);
    chk(pulse_width == exp_w, "R8", "width", 81'(pulse_width), 81'(exp_w));
    if (add_lost) begin
      exp_lost = (exp_lost + 1) % (1 << LW);
      chk(lost_cnt == LW'(exp_lost), "R9", "lost count", 81'(lost_cnt), 81'(exp_lost));
      tot_in = 1'b0;
    end
    @(negedge clk);
    chk(rec_valid == 1'b0, "R3", "strobe one cycle", 81'(rec_valid), 81'(0));
    if (add_lost) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(rec_valid == 1'b0 && busy == 1'b0, "R9", "lost pulse ignored",
            81'({rec_valid, busy}), 81'(0));
      end
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(rec_valid == 0 && busy == 0 && lost_cnt == 0 && rec_data == 0 && pulse_width == 0,
        "R1", "reset state", rec_data | 81'(pulse_width), 81'(0));
    // directed corners of the vote and encoder
    do_hit(32'hFFFF_FFFF, 32'h0000_0000, 5'd31, 1, 1'b0, 1'b0);
    do_hit(32'h0000_00F7, 32'h0000_1007, 5'd3, 2, 1'b0, 1'b0);
    do_hit(32'h8000_0000, 32'h0000_0001, 5'd0, 3, 1'b1, 1'b0);
    do_hit(32'h7FFF_FFFF, 32'hFFFF_FFFE, 5'd17, 70, 1'b0, 1'b1);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] rt, ft;
      rt = therm(int'($urandom % 33));
      ft = therm(int'($urandom % 33));
      if ($urandom % 2) rt[$urandom % 32] ^= 1'b1;
      if ($urandom % 2) ft[$urandom % 32] ^= 1'b1;
      do_hit(rt, ft, 5'($urandom), 1 + int'($urandom % 80),
             1'($urandom % 3 == 0), ($urandom % 6) == 0);
    end
    // drive the lost counter through its wrap
    for (int n = 0; n < 10; n++)
      do_hit(therm(n), therm(31 - n), 5'(n), 1, 1'b0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule